// File: doc/BRIEF.md
# Line-Locked Clock Fan-Out and Reset Sequencer

This block sits after a clock multiplier that runs at four times a line-locked video reference. It fans that fast clock out as two identical full-rate copies, divides it by two into two identical half-rate copies, and produces a half-rate qualifier strobe. The block also drives an active-low system reset. While that reset is active, every clock output is held HIGH, so downstream logic sees no clock edge before the multiplier has locked.

The reset is asserted at once, with no clock needed, when the enable input is LOW or when a power-fail indication is raised. A counter in the fast-clock domain stands in for an analog timing capacitor. The counter advances only while a lock-valid input is HIGH. Reset is released synchronously once the counter has seen a parameterised number of locked cycles. The block also provides a combinational selector that picks one of two reference inputs and passes it to the phase detector.

Top module: `llclk_sequencer`

## Requirements
- R1: While `rst_out_n` is HIGH, `clk4x_a` and `clk4x_b` are both equal to `clk4x`.
- R2: After reset is released, `clk2x_a` and `clk2x_b` are identical. They fall at the first `clk4x` rising edge after the release edge and then change level at every `clk4x` rising edge, which gives half the input rate at 50% duty.
- R3: While `rst_out_n` is LOW, all four clock outputs are HIGH in both phases of `clk4x`.
- R4: `enable` LOW drives `rst_out_n` LOW and the clock outputs HIGH at once, without waiting for a `clk4x` edge.
- R5: `pwr_fail` HIGH drives `rst_out_n` LOW at once and clears the reset count, so that recovery needs the full `RST_CYCLES` again. A partial count from before the event is not resumed.
- R6: With `enable` HIGH, `pwr_fail` LOW and `lock_ok` HIGH, `rst_out_n` rises at exactly the `RST_CYCLES`-th `clk4x` rising edge. It stays LOW after `RST_CYCLES`-1 edges.
- R7: `lock_ok` LOW before release pauses the count without clearing it. Release needs `RST_CYCLES` locked edges in total.
- R8: Once `rst_out_n` is HIGH, `lock_ok` going LOW has no effect on `rst_out_n` or on the clocks.
- R9: `ref_out` equals `ref_a` when `ref_sel` is 0 and equals `ref_b` when `ref_sel` is 1.
- R10: `qual` is LOW during reset. After release it is always the complement of `clk2x_a`, so it rises at the first `clk4x` rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk4x | input | 1 | Fast clock at 4x the reference rate |
| enable | input | 1 | Enable; LOW forces reset |
| pwr_fail | input | 1 | Supply-drop indication; HIGH forces reset and restarts the count |
| lock_ok | input | 1 | Multiplier lock valid; gates the reset counter |
| ref_sel | input | 1 | Reference select, 0 = ref_a, 1 = ref_b |
| ref_a | input | 1 | Reference input one |
| ref_b | input | 1 | Reference input two |
| ref_out | output | 1 | Selected reference |
| clk4x_a | output | 1 | Full-rate clock copy A |
| clk4x_b | output | 1 | Full-rate clock copy B |
| clk2x_a | output | 1 | Half-rate clock copy A |
| clk2x_b | output | 1 | Half-rate clock copy B |
| qual | output | 1 | Half-rate qualifier strobe |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The bench counts release edges exactly. A counter that is off by one releases one edge early or one edge late. It also breaks lock in the middle of the count, which exposes a counter that clears on loss of lock rather than pausing. A power-fail pulse in the middle of a count shows whether a design resumes the old count instead of starting a fresh one. The enable and power-fail events are driven during the LOW phase of the clock, between edges, so a design that asserts reset only on a clock edge leaves the outputs toggling. The first half-rate edges after release are checked to catch a divider that starts in the wrong phase or a qualifier that has drifted out of alignment.

// File: rtl/llc_pkg.sv
package llc_pkg;

  // Next value of the reset counter: advance by one when enabled.
  function automatic int unsigned cnt_next(input int unsigned cur, input logic adv);
    return adv ? cur + 1 : cur;
  endfunction

  // Reset is released once the counter has reached the programmed length.
  function automatic logic cnt_done(input int unsigned cur, input int unsigned len);
    return cur >= len;
  endfunction

  // Clock output while held: forced HIGH when not running.
  function automatic logic hold_high(input logic clk_in, input logic run);
    return clk_in | ~run;
  endfunction

endpackage

// File: rtl/llc_src_sel.sv
module llc_src_sel (
  input  logic sel,
  input  logic in_a,
  input  logic in_b,
  output logic out
);
  always_comb out = sel ? in_b : in_a;
endmodule

// File: rtl/llc_rst_seq.sv
module llc_rst_seq
  import llc_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk4x,
  input  logic hold_n,
  input  logic lock_ok,
  output logic rst_n,
  output logic release_pulse
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  always_comb begin
    adv           = lock_ok && !rst_n;
    cnt_d         = CNT_W'(cnt_next(int'(cnt), adv));
    release_pulse = adv && cnt_done(int'(cnt_d), RST_CYCLES);
  end

  // Asynchronous assertion by hold_n, synchronous release on clk4x.
  always_ff @(posedge clk4x or negedge hold_n) begin
    if (!hold_n) begin
      cnt   <= '0;
      rst_n <= 1'b0;
    end else if (adv) begin
      cnt   <= cnt_d;
      rst_n <= release_pulse;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk4x) disable iff (!hold_n)
    cnt <= CNT_W'(RST_CYCLES));

  assert_release_edge_R6: assert property (@(posedge clk4x) disable iff (!hold_n)
    $rose(rst_n) |-> ($past(cnt) == CNT_W'(RST_CYCLES - 1)));

  assert_lock_pause_R7: assert property (@(posedge clk4x) disable iff (!hold_n)
    (!lock_ok && !rst_n) |=> (!rst_n && $stable(cnt)));

  assert_stay_released_R8: assert property (@(posedge clk4x) disable iff (!hold_n)
    $past(rst_n) |-> rst_n);

endmodule

// File: rtl/llc_clk_fanout.sv
module llc_clk_fanout
  import llc_pkg::*;
#(
  parameter int unsigned N_COPIES = 2
) (
  input  logic                clk4x,
  input  logic                run,
  output logic [N_COPIES-1:0] c4,
  output logic [N_COPIES-1:0] c2,
  output logic                qual
);
  logic half;
  logic qual_q;

  // Divider starts from HIGH so the first change after release is a fall.
  always_ff @(posedge clk4x or negedge run) begin
    if (!run) begin
      half   <= 1'b1;
      qual_q <= 1'b0;
    end else begin
      half   <= ~half;
      qual_q <= half;
    end
  end

  for (genvar i = 0; i < N_COPIES; i++) begin : g_copy
    always_comb begin
      c4[i] = hold_high(clk4x, run);
      c2[i] = hold_high(half, run);
    end
  end

  always_comb qual = qual_q & run;

  assert_half_toggle_R2: assert property (@(posedge clk4x) disable iff (!run)
    $past(run) |-> (half != $past(half)));

  assert_qual_phase_R10: assert property (@(posedge clk4x) disable iff (!run)
    qual_q != half);

endmodule

// File: rtl/llclk_sequencer.sv
module llclk_sequencer #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk4x,
  input  logic enable,
  input  logic pwr_fail,
  input  logic lock_ok,
  input  logic ref_sel,
  input  logic ref_a,
  input  logic ref_b,
  output logic ref_out,
  output logic clk4x_a,
  output logic clk4x_b,
  output logic clk2x_a,
  output logic clk2x_b,
  output logic qual,
  output logic rst_out_n
);
  localparam int unsigned N_COPIES = 2;

  logic                hold_n;
  logic                run;
  logic                release_pulse;
  logic [N_COPIES-1:0] c4;
  logic [N_COPIES-1:0] c2;

  always_comb hold_n = enable & ~pwr_fail;

  llc_src_sel u_sel (
    .sel (ref_sel),
    .in_a(ref_a),
    .in_b(ref_b),
    .out (ref_out)
  );

  llc_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk4x        (clk4x),
    .hold_n       (hold_n),
    .lock_ok      (lock_ok),
    .rst_n        (run),
    .release_pulse(release_pulse)
  );

  llc_clk_fanout #(.N_COPIES(N_COPIES)) u_fan (
    .clk4x(clk4x),
    .run  (run),
    .c4   (c4),
    .c2   (c2),
    .qual (qual)
  );

  always_comb begin
    rst_out_n = run;
    clk4x_a   = c4[0];
    clk4x_b   = c4[1];
    clk2x_a   = c2[0];
    clk2x_b   = c2[1];
  end

  always_comb begin
    if (run === 1'b0) begin
      assert_clk_high_R3: assert (c4 == '1 && c2 == '1 && qual == 1'b0);
    end
  end

  assert_pulse_then_run_R6: assert property (@(posedge clk4x) disable iff (!hold_n)
    release_pulse |=> run);

endmodule

// File: tb/llclk_sequencer_tb.sv
module llclk_sequencer_tb;
  localparam int PERIOD = 10;
  localparam int LEN    = 16;

  logic clk4x = 1'b0;
  logic enable = 1'b0, pwr_fail = 1'b0, lock_ok = 1'b0;
  logic ref_sel = 1'b0, ref_a = 1'b0, ref_b = 1'b0;
  logic ref_out, clk4x_a, clk4x_b, clk2x_a, clk2x_b, qual, rst_out_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // {sel, a, b, expected}
  localparam logic [3:0] REF_VEC [8] = '{
    4'b0_0_0_0, 4'b0_1_0_1, 4'b0_0_1_0, 4'b0_1_1_1,
    4'b1_0_0_0, 4'b1_1_0_0, 4'b1_0_1_1, 4'b1_1_1_1
  };

  llclk_sequencer #(.RST_CYCLES(LEN)) u_dut (
    .clk4x(clk4x), .enable(enable), .pwr_fail(pwr_fail), .lock_ok(lock_ok),
    .ref_sel(ref_sel), .ref_a(ref_a), .ref_b(ref_b), .ref_out(ref_out),
    .clk4x_a(clk4x_a), .clk4x_b(clk4x_b), .clk2x_a(clk2x_a), .clk2x_b(clk2x_b),
    .qual(qual), .rst_out_n(rst_out_n)
  );

  always #(PERIOD/2) clk4x = ~clk4x;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk4x);
      #1;
    end
  endtask

  task automatic chk_held(input string req);
    chk(req, {rst_out_n, clk4x_a, clk4x_b, clk2x_a, clk2x_b, qual}, 6'b0_1111_0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: reference select table
    for (int v = 0; v < 8; v++) begin
      {ref_sel, ref_a, ref_b} = REF_VEC[v][3:1];
      #1;
      chk("R9 ref select", ref_out, REF_VEC[v][0]);
    end

    // Reset state with enable LOW (R3, R4)
    tick(3);
    chk_held("R4 enable low holds reset");
    #5;
    chk_held("R3 held high in low phase");

    // R6: exact release edge
    enable = 1'b1; lock_ok = 1'b1;
    tick(LEN - 1);
    chk("R6 still in reset at LEN-1", rst_out_n, 1'b0);
    #5;
    chk_held("R3 held high before release");
    tick(1);
    chk("R6 released at LEN", rst_out_n, 1'b1);
    chk("R2 half-rate high at release", {clk2x_a, clk2x_b}, 2'b11);
    chk("R10 qual low at release", qual, 1'b0);

    // R1, R2, R10: running outputs
    for (int i = 1; i <= 8; i++) begin
      tick(1);
      chk("R1 full-rate high phase", {clk4x_a, clk4x_b}, 2'b11);
      chk("R2 half-rate level", {clk2x_a, clk2x_b}, (i % 2 == 1) ? 2'b00 : 2'b11);
      chk("R10 qual complement", qual, (i % 2 == 1) ? 1'b1 : 1'b0);
      #5;
      chk("R1 full-rate low phase", {clk4x_a, clk4x_b}, 2'b00);
      chk("R2 half-rate steady in low phase", {clk2x_a, clk2x_b}, (i % 2 == 1) ? 2'b00 : 2'b11);
    end

    // R8: losing lock after release changes nothing
    lock_ok = 1'b0;
    tick(5);
    chk("R8 reset stays released", rst_out_n, 1'b1);
    #5;
    chk("R8 clocks still running", clk4x_a, 1'b0);

    // R4: asynchronous assertion in low phase
    enable = 1'b0;
    #1;
    chk_held("R4 async enable low");

    // R7: lock gates and pauses the count
    tick(1);
    enable = 1'b1;
    tick(2 * LEN);
    chk("R7 no lock no release", rst_out_n, 1'b0);
    lock_ok = 1'b1;
    tick(5);
    lock_ok = 1'b0;
    tick(3);
    lock_ok = 1'b1;
    tick(LEN - 6);
    chk("R7 paused count not yet done", rst_out_n, 1'b0);
    tick(1);
    chk("R7 paused count completes", rst_out_n, 1'b1);

    // R5: power fail asynchronous and restarts the count
    #5;
    pwr_fail = 1'b1;
    #1;
    chk_held("R5 async power fail");
    tick(2);
    pwr_fail = 1'b0;
    tick(5);
    pwr_fail = 1'b1;
    #1;
    pwr_fail = 1'b0;
    tick(LEN - 1);
    chk("R5 fresh count after fail", rst_out_n, 1'b0);
    tick(1);
    chk("R5 release after full count", rst_out_n, 1'b1);
    tick(1);
    chk("R2 first half-rate edge falls", clk2x_a, 1'b0);

    finish_run();
  end
endmodule